// File: doc/BRIEF.md
# Oversampling UART Receiver with Majority Voting

This block receives asynchronous serial frames on one input line and hands each received byte to the core with a one-clock valid strobe. A runtime-loadable divisor turns the system clock into a sample tick, and each bit cell lasts sixteen ticks. The input first passes through a two-flop synchronizer.

The receiver re-aligns only on the high-to-low edge that opens a frame. From that edge it counts its own ticks to find each bit centre. Every bit is decided by a majority of five consecutive samples around the centre, so one noisy sample cannot flip a bit. The start bit is checked the same way. A short low spike on an idle line is therefore dropped instead of being taken as a frame.

If the stop bit votes low, the byte is still placed on the data output and a framing-error pulse is raised instead of the valid strobe. The receiver then waits for the line to return high before it looks for a new start edge.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset, the valid, error and data outputs are all zero. The receiver does not arm for a start edge until it has seen the synchronized line high on a sample tick.
- R2: With a divisor value D on the divisor input, a sample tick occurs every D system clocks, and a value of 0 acts as 1. The divisor may change between frames, and reception follows the new rate.
- R3: A frame is one low start bit, 8 data bits sent least significant bit first, and one high stop bit. A good frame puts the byte on the data output together with a valid pulse that lasts exactly one clock.
- R4: The start bit is voted again around its centre. If that vote is high, for example after a low spike of 2 ticks, no byte and no error are produced, and the receiver returns to idle.
- R5: Each bit value is the majority of 5 consecutive samples taken at ticks 6 to 10 of its 16-tick cell. Tick 0 is the first tick that sees the start edge low. A single-tick inversion at the bit centre does not change the received byte.
- R6: A stop bit that votes low produces a one-clock framing-error pulse and puts the received byte on the data output, with no valid pulse. Valid and error are never high together.
- R7: After a framing error, the receiver starts no new frame while the line stays low. It re-arms only after it samples the line high.
- R8: All bits are timed only from the start edge, using whole 16-tick cells. Frames sent about 3% fast or 3% slow are received correctly. A frame of 0x00 sent 6.25% fast is corrupted and arrives as 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W (16) | System clocks per sample tick (0 acts as 1) |
| rxd_i | input | 1 | Asynchronous serial input, idle high |
| data_o | output | DATA_W (8) | Last received byte |
| valid_o | output | 1 | One-clock strobe for a good frame |
| ferr_o | output | 1 | One-clock strobe for a stop bit that voted low |

## Verification
The assertions check the following on every cycle:
- Valid and error are one-clock pulses and never high together.
- Outputs change only on a sample tick.
- The data output holds still between strobes.
- A rejected start always follows a high centre vote.
- The return from the wait state follows a high line sample.

The bench scenarios are needed for the rest: the actual byte values over a full sweep of all 256 bytes, tolerance to transmitter skew of about ±3%, the deliberate corruption at 6.25% fast skew, rejection of a 2-tick start spike, immunity to a one-tick spike at a bit centre, and the refusal to re-arm while the line stays low after a framing error.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

    localparam int OVS_DEF    = 16;
    localparam int VOTE_DEF   = 5;
    localparam int DATA_DEF   = 8;
    localparam int DIVW_DEF   = 16;

    typedef enum logic [2:0] {
        ST_WAIT_HIGH = 3'd0,
        ST_IDLE      = 3'd1,
        ST_START     = 3'd2,
        ST_DATA      = 3'd3,
        ST_STOP      = 3'd4
    } rx_state_e;

    // tick on which the centred vote window is complete
    function automatic int decide_tick(input int ovs, input int nvote);
        return ovs / 2 + nvote / 2;
    endfunction

endpackage

// File: rtl/uvr_sync.sv
module uvr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff <= 1'b1;
                else     ff <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= {ff[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = ff[STAGES-1];
endmodule

// File: rtl/uvr_prescale.sv
module uvr_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim    = (div_i == '0) ? '0 : div_i - 1'b1;
        tick_o = (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uvr_vote.sv
module uvr_vote #(
    parameter int NVOTE = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic smp_i,
    output logic vote_o
);
    localparam int CW = $clog2(NVOTE + 1);
    localparam logic [CW-1:0] HALF = CW'(NVOTE / 2);

    logic [NVOTE-2:0] win;
    logic [NVOTE-1:0] all_s;
    logic [CW-1:0]    ones;

    always_ff @(posedge clk) begin
        if (rst)         win <= '1;
        else if (tick_i) win <= {win[NVOTE-3:0], smp_i};
    end

    always_comb begin
        all_s = {win, smp_i};
        ones  = '0;
        for (int i = 0; i < NVOTE; i++) ones = ones + CW'(all_s[i]);
        vote_o = (ones > HALF);
    end
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
    import uvr_pkg::*;
#(
    parameter int DATA_W = DATA_DEF,
    parameter int DIV_W  = DIVW_DEF,
    parameter int OVS    = OVS_DEF,
    parameter int NVOTE  = VOTE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              rxd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              ferr_o
);
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [TW-1:0] T_DEC  = TW'(decide_tick(OVS, NVOTE));
    localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
    localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

    logic        rx_s;
    logic        tick_w;
    logic        vote_w;
    rx_state_e   st;
    logic [TW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] shreg;

    uvr_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d_i(rxd_i), .q_o(rx_s)
    );

    uvr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .div_i(div_i), .tick_o(tick_w)
    );

    uvr_vote #(.NVOTE(NVOTE)) u_vote (
        .clk(clk), .rst(rst), .tick_i(tick_w), .smp_i(rx_s), .vote_o(vote_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_WAIT_HIGH;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
            if (tick_w) begin
                case (st)
                    ST_WAIT_HIGH: begin
                        if (rx_s) st <= ST_IDLE;
                    end
                    ST_IDLE: begin
                        if (!rx_s) begin
                            st   <= ST_START;
                            tcnt <= TW'(1);
                        end
                    end
                    default: begin
                        tcnt <= (tcnt == T_LAST) ? '0 : tcnt + 1'b1;
                        if (tcnt == T_DEC) begin
                            case (st)
                                ST_START: begin
                                    if (vote_w) st <= ST_IDLE;
                                end
                                ST_DATA: begin
                                    shreg <= {vote_w, shreg[DATA_W-1:1]};
                                end
                                ST_STOP: begin
                                    data_o <= shreg;
                                    if (vote_w) begin
                                        valid_o <= 1'b1;
                                        st      <= ST_IDLE;
                                    end else begin
                                        ferr_o  <= 1'b1;
                                        st      <= ST_WAIT_HIGH;
                                    end
                                end
                                default: st <= ST_WAIT_HIGH;
                            endcase
                        end else if (tcnt == T_LAST) begin
                            case (st)
                                ST_START: begin
                                    st   <= ST_DATA;
                                    bidx <= '0;
                                end
                                ST_DATA: begin
                                    if (bidx == B_LAST) st <= ST_STOP;
                                    else                bidx <= bidx + 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk
    import uvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              rx_s,
    input logic              vote,
    input rx_state_e         st,
    input logic [DATA_W-1:0] data_o,
    input logic              valid_o,
    input logic              ferr_o
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid_o && !ferr_o && data_o == '0)); // R1

    AST_OUT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (valid_o || ferr_o) |-> $past(tick)); // R2

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R3

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(valid_o || ferr_o) |-> $stable(data_o)); // R3

    AST_START_REJECT: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_START && st == ST_IDLE) |-> $past(vote)); // R4

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        ferr_o |=> !ferr_o); // R6

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ferr_o && valid_o)); // R6

    AST_REARM_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_WAIT_HIGH && st == ST_IDLE) |-> $past(rx_s)); // R7
endmodule

bind uart_vote_rx uart_vote_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick_w), .rx_s(rx_s), .vote(vote_w),
    .st(st), .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
);

// File: tb/sim_uart_vote_rx.sv
`timescale 1ns/1ps
module sim_uart_vote_rx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] div = 16'd2;
    logic        rxd = 1'b1;
    logic [7:0]  data_o;
    logic        valid_o;
    logic        ferr_o;

    int n_run  = 0;
    int n_fail = 0;
    int vcnt   = 0;
    int ecnt   = 0;
    logic [7:0] last_v = '0;
    logic [7:0] last_e = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_vote_rx u0 (
        .clk(clk), .rst(rst), .div_i(div), .rxd_i(rxd),
        .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
    );

    always @(negedge clk) begin
        if (!rst && valid_o) begin vcnt++; last_v = data_o; end
        if (!rst && ferr_o)  begin ecnt++; last_e = data_o; end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        rxd = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // per: clocks per bit; gbit: data bit with a centre spike (-1 none)
    task automatic send(input logic [7:0] b, input int per,
                        input logic stopv, input int gbit);
        logic [9:0] fr;
        fr = {stopv, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            if (gbit >= 0 && i == gbit + 1) begin
                rxd = fr[i];
                repeat (per / 2 - 1) @(negedge clk);
                rxd = ~fr[i];
                repeat (2) @(negedge clk);
                rxd = fr[i];
                repeat (per - per / 2 - 1) @(negedge clk);
            end else begin
                rxd = fr[i];
                repeat (per) @(negedge clk);
            end
        end
    endtask

    task automatic frame_ok(input logic [7:0] b, input int per, input string req);
        int v0, e0;
        v0 = vcnt; e0 = ecnt;
        send(b, per, 1'b1, -1);
        idle(2 * per);
        chk(vcnt == v0 + 1 && ecnt == e0, req, "one valid, no error", vcnt - v0, 1);
        chk(last_v == b, req, "byte", last_v, b);
    endtask

    initial begin
        int v0, e0;
        repeat (4) @(negedge clk);
        chk(valid_o == 0 && ferr_o == 0 && data_o == 0, "R1", "reset outputs",
            {data_o, valid_o, ferr_o}, 0);
        rst = 1'b0;
        idle(40);

        // R3 / R5: every byte at nominal rate, divisor 2 -> 32 clocks per bit
        for (int b = 0; b < 256; b++) frame_ok(8'(b), 32, "R3");

        // R5: one-tick spike at the centre of a data bit
        v0 = vcnt;
        send(8'h00, 32, 1'b1, 3); idle(64);
        chk(vcnt == v0 + 1 && last_v == 8'h00, "R5", "spike in bit3", last_v, 8'h00);
        v0 = vcnt;
        send(8'hFF, 32, 1'b1, 6); idle(64);
        chk(vcnt == v0 + 1 && last_v == 8'hFF, "R5", "spike in bit6", last_v, 8'hFF);

        // R4: 2-tick low spike on idle line (4 clocks at divisor 2)
        v0 = vcnt; e0 = ecnt;
        rxd = 1'b0; repeat (4) @(negedge clk);
        idle(12 * 32);
        chk(vcnt == v0 && ecnt == e0, "R4", "spike gives no output",
            (vcnt - v0) + (ecnt - e0), 0);
        frame_ok(8'hA5, 32, "R4");

        // R6 / R7: stop bit low, line held low for ten bit times
        v0 = vcnt; e0 = ecnt;
        send(8'h3C, 32, 1'b0, -1);
        repeat (10 * 32) @(negedge clk);
        chk(ecnt == e0 + 1, "R6", "one framing error", ecnt - e0, 1);
        chk(vcnt == v0, "R6", "no valid on bad stop", vcnt - v0, 0);
        chk(last_e == 8'h3C && data_o == 8'h3C, "R6", "byte presented", data_o, 8'h3C);
        chk(ecnt == e0 + 1, "R7", "no re-arm while low", ecnt - e0, 1);
        idle(64);
        frame_ok(8'h5A, 32, "R7");

        // R8: transmitter skew about +/-3 %
        for (int k = 0; k < 8; k++) begin
            frame_ok(8'(k * 37 + 1), 31, "R8");
            frame_ok(8'(k * 53 + 2), 33, "R8");
        end
        frame_ok(8'h00, 31, "R8");
        frame_ok(8'hFF, 33, "R8");

        // R8: 6.25 % fast transmitter corrupts the last data bit
        v0 = vcnt;
        send(8'h00, 30, 1'b1, -1); idle(64);
        chk(vcnt == v0 + 1 && last_v == 8'h80, "R8", "6.25% fast corrupts",
            last_v, 8'h80);

        // R2: other divisors, including 0 acting as 1
        div = 16'd3; idle(100);
        frame_ok(8'hC3, 48, "R2");
        frame_ok(8'h81, 48, "R2");
        div = 16'd1; idle(50);
        frame_ok(8'h7E, 16, "R2");
        div = 16'd0; idle(50);
        frame_ok(8'h19, 16, "R2");
        div = 16'd2; idle(50);
        frame_ok(8'hE7, 32, "R2");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule